// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block takes one converted sample per sample strobe from a conversion core and puts it on a twelve-lane parallel output bus, together with a forwarded output clock and an over-range flag that belongs to the same sample. The core hands over a raw value one bit wider than the output word. Any raw value at or above positive full scale is clamped to full scale, and it raises the over-range flag instead of wrapping.

Two bus formats exist. In single data rate format every lane carries its own bit for the whole sample. In double data rate format only the even-numbered lanes are driven, and each one carries two bits of the sample, one per output clock phase. During the low phase the odd-indexed bits go out, which include the MSB. During the high phase the even-indexed bits go out, which include the LSB. The format comes from a three-level strap input. A configuration write selects a format directly and, from then on until reset, takes precedence over the strap.

The block runs on a clock at twice the sample rate. The forwarded output clock toggles on every cycle of it. An upstream source delivers each sample while the output clock is high, so that the sample then fills one low phase followed by one high phase. A synchronous clear blanks the bus and the flag until the next sample arrives.

Top module: `smpfmt_top`

## Requirements
- R1: While rst_n is low, dout, oclk and ovr_flag are all zero.
- R2: After reset, oclk inverts on every rising clk edge.
- R3: In single data rate format, a sample accepted at an edge appears as the whole 12-bit word on dout after that edge, and it stays there for both phases.
- R4: In double data rate format, while oclk is low, lane 2k carries bit 2k+1 of the held word (k = 0..5), so lane 10 carries the MSB.
- R5: In double data rate format, while oclk is high, lane 2k carries bit 2k of the held word, so lane 0 carries the LSB.
- R6: In double data rate format, all odd-numbered lanes are zero.
- R7: A raw 13-bit value of 0xFFF or more is output as 0xFFF with ovr_flag = 1. A smaller value is output unchanged in its low 12 bits with ovr_flag = 0.
- R8: ovr_flag updates at the same edge as the data word it belongs to, one clk after the sample is accepted.
- R9: In a cycle with smp_valid low and clr low, the held word and the flag do not change.
- R10: The strap codes are: 2'b00 (tied low) and 2'b01 (tied high) select double data rate, and 2'b10 or 2'b11 (floating) select single data rate. The strap takes effect one clk later.
- R11: A cycle with cfg_wr high selects double data rate if cfg_ddr = 1 and single data rate if cfg_ddr = 0. After such a write, strap changes have no effect until reset.
- R12: clr high zeros the held word and the flag at the next edge. Both stay zero until the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_lvl | input | 2 | Encoded three-level format strap |
| cfg_wr | input | 1 | Format override write strobe |
| cfg_ddr | input | 1 | Format written by cfg_wr (1 = double data rate) |
| clr | input | 1 | Blank the bus and flag until the next sample |
| smp_valid | input | 1 | Sample strobe |
| smp_raw | input | 13 | Raw sample, one bit above full scale |
| dout | output | 12 | Parallel output lanes |
| oclk | output | 1 | Forwarded output clock |
| ovr_flag | output | 1 | Over-range flag for the held sample |

## Verification
The hardest behaviour to reach from the ports is the per-phase lane mapping of a sample held across a low/high pair. It is only visible if every sample lands exactly when oclk is high. The driver therefore waits for that phase before it asserts the strobe, and the monitor checks both phases of each sample against a mapping it computes itself. The second hard case is an override that must beat a later strap change. The stimulus writes the override and then moves the strap to the opposite format before it sends a sample.

// File: rtl/smpfmt_pkg.sv
package smpfmt_pkg;

    typedef enum logic {
        FMT_SDR = 1'b0,
        FMT_DDR = 1'b1
    } fmt_e;

    // strap_lvl[1] set means the strap pin is left floating
    localparam int unsigned STRAP_FLOAT_BIT = 1;

endpackage

// File: rtl/smpfmt_mode_sel.sv
module smpfmt_mode_sel
    import smpfmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_lvl,
    input  logic       cfg_wr,
    input  logic       cfg_ddr,
    output fmt_e       fmt
);

    typedef struct packed {
        logic ovr;
        fmt_e ovr_fmt;
        fmt_e fmt;
    } mode_st;

    mode_st st_d, st_q;
    fmt_e   strap_fmt;

    always_comb begin
        st_d      = st_q;
        strap_fmt = strap_lvl[STRAP_FLOAT_BIT] ? FMT_SDR : FMT_DDR;
        if (cfg_wr) begin
            st_d.ovr     = 1'b1;
            st_d.ovr_fmt = cfg_ddr ? FMT_DDR : FMT_SDR;
        end
        st_d.fmt = st_d.ovr ? st_d.ovr_fmt : strap_fmt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ovr: 1'b0, ovr_fmt: FMT_SDR, fmt: FMT_SDR};
        end else begin
            st_q <= st_d;
        end
    end

    assign fmt = st_q.fmt;

    // R11: once written, the override stays in force
    p_override_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovr |=> st_q.ovr);

    // R11: while overridden, a strap change leaves the format alone
    p_strap_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !cfg_wr) |=> $stable(st_q.fmt));

endmodule

// File: rtl/smpfmt_capture.sv
module smpfmt_capture #(
    parameter int unsigned DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          smp_valid,
    input  logic [DW:0]   smp_raw,
    output logic [DW-1:0] word,
    output logic          ovr
);

    localparam logic [DW-1:0] FULL     = {DW{1'b1}};
    localparam logic [DW:0]   FULL_EXT = {1'b0, FULL};

    typedef struct packed {
        logic [DW-1:0] word;
        logic          ovr;
    } cap_st;

    cap_st cap_d, cap_q;
    logic  sat;

    always_comb begin
        cap_d = cap_q;
        sat   = (smp_raw >= FULL_EXT);
        if (clr) begin
            cap_d.word = '0;
            cap_d.ovr  = 1'b0;
        end else if (smp_valid) begin
            cap_d.word = sat ? FULL : smp_raw[DW-1:0];
            cap_d.ovr  = sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word = cap_q.word;
    assign ovr  = cap_q.ovr;

    // R7: a raised flag always comes with a clamped full-scale word
    p_flag_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.ovr |-> (cap_q.word == FULL));

    // R8: an over-range input shows word and flag on the same edge
    p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !clr && (smp_raw > FULL_EXT)) |=> (cap_q.ovr && (cap_q.word == FULL)));

    // R9: with no strobe and no clear, the captured sample holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !clr) |=> ($stable(cap_q.word) && $stable(cap_q.ovr)));

    // R12: a clear blanks the word and the flag
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((cap_q.word == '0) && !cap_q.ovr));

endmodule

// File: rtl/smpfmt_lane_map.sv
module smpfmt_lane_map
    import smpfmt_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input  logic [DW-1:0] word,
    input  logic          phase_hi,
    input  fmt_e          fmt,
    output logic [DW-1:0] lanes
);

    localparam int unsigned PAIRS = DW / 2;

    logic [DW-1:0] ddr_v;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        // even lane: odd bit on the low phase, even bit on the high phase
        assign ddr_v[2*k]   = phase_hi ? word[2*k] : word[2*k+1];
        assign ddr_v[2*k+1] = 1'b0;
    end

    assign lanes = (fmt == FMT_DDR) ? ddr_v : word;

endmodule

// File: rtl/smpfmt_top.sv
module smpfmt_top
    import smpfmt_pkg::*;
#(
    parameter int unsigned DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    strap_lvl,
    input  logic          cfg_wr,
    input  logic          cfg_ddr,
    input  logic          clr,
    input  logic          smp_valid,
    input  logic [DW:0]   smp_raw,
    output logic [DW-1:0] dout,
    output logic          oclk,
    output logic          ovr_flag
);

    function automatic logic [DW-1:0] odd_lane_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int i = 1; i < int'(DW); i += 2) begin
            m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DW-1:0] ODD_MASK = odd_lane_mask();

    typedef struct packed {
        logic oclk;
    } clk_st;

    clk_st         ck_d, ck_q;
    fmt_e          fmt;
    logic [DW-1:0] word;
    logic          ovr;

    always_comb begin
        ck_d      = ck_q;
        ck_d.oclk = ~ck_q.oclk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q <= '0;
        end else begin
            ck_q <= ck_d;
        end
    end

    smpfmt_mode_sel i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_lvl (strap_lvl),
        .cfg_wr    (cfg_wr),
        .cfg_ddr   (cfg_ddr),
        .fmt       (fmt)
    );

    smpfmt_capture #(.DW(DW)) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .smp_valid (smp_valid),
        .smp_raw   (smp_raw),
        .word      (word),
        .ovr       (ovr)
    );

    smpfmt_lane_map #(.DW(DW)) i_map (
        .word     (word),
        .phase_hi (ck_q.oclk),
        .fmt      (fmt),
        .lanes    (dout)
    );

    assign oclk     = ck_q.oclk;
    assign ovr_flag = ovr;

    // R2: the forwarded clock flips on every edge
    p_oclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (oclk != $past(oclk)));

    // R6: in double data rate format odd lanes stay idle
    p_odd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_DDR) |-> ((dout & ODD_MASK) == '0));

endmodule

// File: tb/test_smpfmt_top.sv
`timescale 1ns/1ps
module test_smpfmt_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  strap_lvl;
    logic        cfg_wr;
    logic        cfg_ddr;
    logic        clr;
    logic        smp_valid;
    logic [12:0] smp_raw;
    logic [11:0] dout;
    logic        oclk;
    logic        ovr_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    bit exp_ddr = 1'b0;

    typedef struct packed {
        logic [11:0] code;
        logic        flag;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    smpfmt_top i_smpfmt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_lvl (strap_lvl),
        .cfg_wr    (cfg_wr),
        .cfg_ddr   (cfg_ddr),
        .clr       (clr),
        .smp_valid (smp_valid),
        .smp_raw   (smp_raw),
        .dout      (dout),
        .oclk      (oclk),
        .ovr_flag  (ovr_flag)
    );

    task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ddr_view(logic [11:0] code, bit hi);
        logic [11:0] v = '0;
        for (int k = 0; k < 6; k++) begin
            v[2*k] = hi ? code[2*k] : code[2*k+1];
        end
        return v;
    endfunction

    // driver: aligns each sample to the high oclk phase
    task automatic send(logic [12:0] raw, string tag);
        item_t it;
        @(negedge clk);
        while (!oclk) @(negedge clk);
        it.flag = (raw >= 13'h0FFF);               // R7 saturation rule
        it.code = it.flag ? 12'hFFF : raw[11:0];
        exp_q.push_back(it);
        tag_q.push_back(tag);
        smp_valid = 1'b1;
        smp_raw   = raw;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: compares both cycles that follow each accepted sample
    always begin
        @(posedge clk);
        if (rst_n && smp_valid && !clr) begin
            item_t it;
            string tg;
            bit    m;
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            m  = exp_ddr;
            #1;
            if (m) begin
                chk({tg, " R4 low phase"}, {oclk, ovr_flag, dout[10:0]},
                    {1'b0, it.flag, ddr_view(it.code, 1'b0)[10:0]});
                chk({tg, " R6 odd lanes, R8 flag"}, {ovr_flag, dout},
                    {it.flag, ddr_view(it.code, 1'b0)});
                @(posedge clk);
                #1;
                chk({tg, " R5 high phase"}, {ovr_flag, dout},
                    {it.flag, ddr_view(it.code, 1'b1)});
            end else begin
                chk({tg, " R3 word, R8 flag"}, {ovr_flag, dout}, {it.flag, it.code});
                @(posedge clk);
                #1;
                chk({tg, " R9 hold"}, {ovr_flag, dout}, {it.flag, it.code});
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit prev;
        rst_n     = 1'b0;
        strap_lvl = 2'b10;
        cfg_wr    = 1'b0;
        cfg_ddr   = 1'b0;
        clr       = 1'b0;
        smp_valid = 1'b0;
        smp_raw   = '0;
        idle(4);
        chk("R1 reset state", {oclk, ovr_flag, dout[10:0]}, 13'h0);
        chk("R1 reset msb", {12'h0, dout[11]}, 13'h0);
        rst_n = 1'b1;

        // R2: oclk alternates
        prev = oclk;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R2 oclk toggle", {12'h0, oclk}, {12'h0, ~prev});
            prev = oclk;
        end

        // single data rate via floating strap, R10
        send(13'h05A3, "R10 float");
        send(13'h0000, "R3 zero");
        send(13'h0FFE, "R7 below");
        send(13'h0FFF, "R7 at full");
        send(13'h1234, "R7 above");
        send(13'h07FF, "R3 mid");
        idle(4);

        // strap tied low: double data rate
        strap_lvl = 2'b00;
        idle(3);
        exp_ddr = 1'b1;
        send(13'h0A5C, "R10 low");
        send(13'h0001, "R5 lsb");
        send(13'h0800, "R4 msb");
        send(13'h1FFF, "R7 ddr");
        send(13'h0555, "R4 pattern");
        idle(4);

        // strap tied high: still double data rate
        strap_lvl = 2'b01;
        idle(3);
        send(13'h0AAA, "R10 high");
        idle(4);

        // strap floating with code 11: single data rate
        strap_lvl = 2'b11;
        idle(3);
        exp_ddr = 1'b0;
        send(13'h0C3C, "R10 float11");
        idle(4);

        // override to double data rate, then move strap to SDR
        cfg_ddr = 1'b1;
        cfg_wr  = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
        strap_lvl = 2'b10;
        idle(3);
        exp_ddr = 1'b1;
        send(13'h0F0F, "R11 ovr ddr");
        idle(4);

        // override to SDR against a DDR strap
        strap_lvl = 2'b00;
        cfg_ddr   = 1'b0;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        idle(3);
        exp_ddr = 1'b0;
        send(13'h0369, "R11 ovr sdr");
        idle(4);

        // clear blanks bus and flag until the next sample
        send(13'h1FFF, "R12 pre");
        idle(1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R12 cleared", {ovr_flag, dout}, 13'h0);
        idle(3);
        chk("R12 stays clear", {ovr_flag, dout}, 13'h0);
        send(13'h0123, "R12 resume");
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule